// File: doc/BRIEF.md
# Synchronous Serial Transfer Unit

This block moves one 8-bit or 16-bit word over a clocked three-wire serial link, sending and receiving at the same time. Software loads the outgoing word into two byte-wide data registers and sets a start bit. The unit then shifts the word out on the data output, least significant bit first. On the same serial clock it shifts the incoming word into the same registers. When the last bit has been taken in, it raises a completion interrupt flag and stops.

The serial clock can come from inside or outside. Taken from inside, it is the system clock divided by a power of two chosen by a 4-bit rate field, and it toggles only while a transfer runs. Taken from outside, the unit follows the edges on the clock input. It flags an overrun if edges keep coming after the transfer has finished. Between transfers the data output holds the last bit sent until software writes a new idle level. A control write with the hold bit cleared abandons a transfer in progress.

Registers sit at a 2-bit address. Address 0 is control. Address 1 is the lower data byte and address 2 the upper data byte. Address 3 is status. Reads are combinational and writes take effect on the clock edge that samples `reg_wr`.

Top module: `sync_serial_xfer`

## Requirements
- R1: After reset:
  - control, lower data and upper data read 0;
  - status reads 0x08;
  - `sclk_out`, `sclk_oe` and `sdo` are 1, and `xfer_irq` is 0.
- R2: Writing status (address 3) with bit 0 set starts a transfer when none is running. Status bit 0 reads 1 while the transfer runs and returns to 0 by itself when it completes.
- R3: With the internal clock (control bit 4 = 0), each half period of `sclk_out` lasts 2^N system clocks, where N is control bits 3:0.
  - The first fall comes 2^N clocks after the start edge.
  - A transfer has 8 low pulses when control bit 5 = 0 and 16 when it is 1.
  - `sclk_out` stays 1 whenever no transfer runs.
- R4: Transmit bits leave least significant bit first. Bit 0 is on `sdo` from the start edge, and each later bit appears at a falling serial clock edge.
- R5: `sdi` is sampled on each rising serial clock edge, least significant bit first.
  - In 8-bit mode the received byte replaces the lower data register and the upper register is untouched.
  - In 16-bit mode the upper received byte lands in address 2 and the lower in address 1.
- R6: The completion flag, status bit 2, is driven on `xfer_irq`.
  - It is set on the final rising edge of a transfer.
  - It is cleared only by writing status with bit 2 = 0. Writing 1 to it has no effect.
- R7: After completion `sdo` keeps the value of the last bit sent.
- R8: With the external clock (control bit 4 = 1):
  - `sclk_oe` is 0;
  - bits are shifted on the edges of `sclk_in`, output on falls and input on rises.
- R9: In external clock mode, a rising edge of `sclk_in` after a completed transfer shifts no data and sets the overrun flag, status bit 1. Writing status bit 1 as 0 clears it.
- R10: Writing status while no transfer runs sets `sdo` to the written bit 3 from the next cycle, and status bit 3 reads back that value.
- R11: A control write with bit 6 = 0 abandons a running transfer:
  - status bit 0 clears;
  - `sclk_out` returns to 1 and stays there;
  - no completion flag is raised.
- R12: While a transfer runs, writes to the data registers and further start requests are ignored. The received data and the completion time are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 lower data, 2 upper data, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internal serial clock, idle high |
| sclk_oe | output | 1 | 1 when the unit drives the serial clock |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| xfer_irq | output | 1 | Completion interrupt request flag |

## Verification
Five properties are checked on every cycle:
- the serial clock stays high and unchanged while idle;
- `sdo` holds still while idle unless status is written;
- during an internal transfer, `sdo` moves only on falling serial clock edges;
- every end of a transfer that was not an abort raises the completion flag.

Some behaviour needs whole scenarios and the bench's reference model. That covers the exact clock timing for several rate settings, the bit order both ways, which data register each received byte lands in, and the overrun after extra external edges. It also covers that writes made during a transfer are ignored and that an abort leaves no completion.

// File: rtl/sst_pkg.sv
// Shared constants for the synchronous serial transfer unit: default widths,
// register addresses and the bit positions software relies on.
package sst_pkg;
    localparam int SST_BYTE_W = 8;
    localparam int SST_SEL_W  = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DLO  = 2'd1,
        REG_DHI  = 2'd2,
        REG_STAT = 2'd3
    } sst_reg_e;

    // Control register fields above the clock-rate field.
    localparam int CTRL_EXT  = 4;
    localparam int CTRL_WIDE = 5;
    localparam int CTRL_HOLD = 6;

    // Status register fields.
    localparam int STAT_RUN  = 0;
    localparam int STAT_OVR  = 1;
    localparam int STAT_DONE = 2;
    localparam int STAT_LVL  = 3;
endpackage

// File: rtl/sst_clkdiv.sv
// Rate divider: while run is high it pulses tick once every 2^sel system
// clocks, which marks each half period of the internal serial clock.
// Assumes the counter restarts from zero whenever run is low.
module sst_clkdiv #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = 1 << SEL_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    assign half_m1 = (CNT_W'(1) << sel) - CNT_W'(1);
    assign tick    = run && (cnt == half_m1);

    // Half-period counter, cleared when idle or at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                  cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/sst_edge_sync.sv
// Brings the external serial clock into the system clock domain and reports
// its rising and falling edges as one-cycle pulses. Assumes the external
// clock stays in each level for several system clocks; idles high.
module sst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/sst_shifter.sv
// Shift engine: the data registers double as the shift chain. On rising
// events it moves sdi in at the top of the active length, and on falling
// events it presents the next transmit bit (LSB first) on a separate output
// register, so the last bit sent survives the final shift. Assumes start,
// abort and register writes are never asserted together.
module sst_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  abort,
    input  logic                  wide,
    input  logic                  rise_evt,
    input  logic                  fall_evt,
    input  logic                  sdi,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  lvl_wr,
    input  logic                  lvl_val,
    output logic [2*BYTE_W-1:0]   data,
    output logic                  sdo,
    output logic                  busy,
    output logic                  finish
);
    localparam int DW    = 2 * BYTE_W;
    localparam int CNT_W = $clog2(DW);

    logic [DW-1:0]    sr;
    logic [CNT_W-1:0] bitcnt;
    logic [CNT_W-1:0] last_idx;
    logic             busy_q;
    logic             sdo_q;

    assign last_idx = wide ? CNT_W'(DW - 1) : CNT_W'(BYTE_W - 1);
    assign finish   = busy_q && rise_evt && (bitcnt == last_idx);

    // Data/shift register: loaded by software when idle, shifted when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (busy_q) begin
            if (rise_evt) begin
                if (wide) sr <= {sdi, sr[DW-1:1]};
                else      sr[BYTE_W-1:0] <= {sdi, sr[BYTE_W-1:1]};
            end
        end else begin
            if (wr_lo) sr[BYTE_W-1:0]  <= wdata;
            if (wr_hi) sr[DW-1:BYTE_W] <= wdata;
        end
    end

    // Bit counter: counts rising events within one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bitcnt <= '0;
        else if (abort || start)    bitcnt <= '0;
        else if (busy_q && rise_evt) bitcnt <= bitcnt + CNT_W'(1);
    end

    // Busy flag: set by start, cleared by abort or the final rising event.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (abort)  busy_q <= 1'b0;
        else if (start)  busy_q <= 1'b1;
        else if (finish) busy_q <= 1'b0;
    end

    // Output bit: first bit at start, next bit at each fall, idle level on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sdo_q <= 1'b1;
        else if (start)              sdo_q <= sr[0];
        else if (busy_q && fall_evt) sdo_q <= sr[0];
        else if (!busy_q && lvl_wr)  sdo_q <= lvl_val;
    end

    assign data = sr;
    assign sdo  = sdo_q;
    assign busy = busy_q;
endmodule

// File: rtl/sync_serial_xfer.sv
// Synchronous serial transfer unit top: register file, serial clock
// generation or tracking, status flags, and the shift engine. Assumes the
// external serial clock is much slower than clk.
module sync_serial_xfer
    import sst_pkg::*;
#(
    parameter int BYTE_W      = SST_BYTE_W,
    parameter int SEL_W       = SST_SEL_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              xfer_irq
);
    localparam int DW = 2 * BYTE_W;

    logic [BYTE_W-1:0] ctrl_q;
    logic              ext_mode, wide_mode;
    logic              ctrl_wr, stat_wr, lo_wr, hi_wr;
    logic              ctrl_abort, start_req;
    logic              busy, finish;
    logic              tick, int_rise, int_fall;
    logic              ext_rise, ext_fall;
    logic              rise_evt, fall_evt;
    logic              sclk_q;
    logic              done_q, ovr_q, lvl_q, post_done_q;
    logic [DW-1:0]     data;
    logic [BYTE_W-1:0] stat_view;

    // Register write decode.
    assign ctrl_wr    = reg_wr && (reg_addr == REG_CTRL);
    assign lo_wr      = reg_wr && (reg_addr == REG_DLO);
    assign hi_wr      = reg_wr && (reg_addr == REG_DHI);
    assign stat_wr    = reg_wr && (reg_addr == REG_STAT);
    assign ctrl_abort = ctrl_wr && !reg_wdata[CTRL_HOLD];
    assign start_req  = stat_wr && reg_wdata[STAT_RUN] && !busy;

    assign ext_mode  = ctrl_q[CTRL_EXT];
    assign wide_mode = ctrl_q[CTRL_WIDE];

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= reg_wdata;
    end

    sst_clkdiv #(.SEL_W(SEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy && !ext_mode),
        .sel   (ctrl_q[SEL_W-1:0]),
        .tick  (tick)
    );

    sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    assign int_fall = tick && sclk_q;
    assign int_rise = tick && !sclk_q;
    assign rise_evt = ext_mode ? ext_rise : int_rise;
    assign fall_evt = ext_mode ? ext_fall : int_fall;

    // Internal serial clock: toggles on ticks while busy, high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                       sclk_q <= 1'b1;
        else if (ctrl_abort || !busy)     sclk_q <= 1'b1;
        else if (!ext_mode && tick)       sclk_q <= ~sclk_q;
    end

    sst_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_req),
        .abort    (ctrl_abort),
        .wide     (wide_mode),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .sdi      (sdi),
        .wr_lo    (lo_wr && !busy),
        .wr_hi    (hi_wr && !busy),
        .wdata    (reg_wdata),
        .lvl_wr   (stat_wr && !busy && !start_req),
        .lvl_val  (reg_wdata[STAT_LVL]),
        .data     (data),
        .sdo      (sdo),
        .busy     (busy),
        .finish   (finish)
    );

    // Completion flag: set wins over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                done_q <= 1'b0;
        else if (finish)                           done_q <= 1'b1;
        else if (stat_wr && !reg_wdata[STAT_DONE]) done_q <= 1'b0;
    end

    // Marks that a transfer has ended and no new one has started yet.
    always_ff @(posedge clk) begin
        if (!rst_n)                        post_done_q <= 1'b0;
        else if (start_req || ctrl_abort)  post_done_q <= 1'b0;
        else if (finish)                   post_done_q <= 1'b1;
    end

    // Overrun flag: external rising edge after completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        ovr_q <= 1'b0;
        else if (ext_mode && !busy && post_done_q && ext_rise) ovr_q <= 1'b1;
        else if (stat_wr && !reg_wdata[STAT_OVR])          ovr_q <= 1'b0;
    end

    // Idle output level bit, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 lvl_q <= 1'b1;
        else if (stat_wr && !busy)  lvl_q <= reg_wdata[STAT_LVL];
    end

    // Status register read view.
    always_comb begin
        stat_view            = '0;
        stat_view[STAT_RUN]  = busy;
        stat_view[STAT_OVR]  = ovr_q;
        stat_view[STAT_DONE] = done_q;
        stat_view[STAT_LVL]  = lvl_q;
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = ctrl_q;
            REG_DLO:  reg_rdata = data[BYTE_W-1:0];
            REG_DHI:  reg_rdata = data[DW-1:BYTE_W];
            default:  reg_rdata = stat_view;
        endcase
    end

    assign sclk_out = sclk_q;
    assign sclk_oe  = !ext_mode;
    assign xfer_irq = done_q;
endmodule

// File: rtl/sync_serial_xfer_chk.sv
// Property checker for sync_serial_xfer, attached by bind below.
module sync_serial_xfer_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic ext_mode,
    input logic ctrl_abort,
    input logic stat_wr,
    input logic sclk_out,
    input logic sdo,
    input logic xfer_irq
);
    // R3: the serial clock rests high whenever no transfer runs
    p_clk_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

    // R3: the serial clock only moves on the edge after a busy cycle
    p_clk_moves_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_out) |-> $past(busy));

    // R7, R10: idle output holds unless status is written
    p_sdo_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !stat_wr) |=> $stable(sdo));

    // R4: during an internal transfer sdo changes only at a falling clock
    p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && busy && $past(busy) && !$stable(sdo)) |-> $fell(sclk_out));

    // R6: a transfer that ends without abort raises the completion flag
    p_irq_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(ctrl_abort)) |-> xfer_irq);
endmodule

bind sync_serial_xfer sync_serial_xfer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .ext_mode   (ext_mode),
    .ctrl_abort (ctrl_abort),
    .stat_wr    (stat_wr),
    .sclk_out   (sclk_out),
    .sdo        (sdo),
    .xfer_irq   (xfer_irq)
);

// File: tb/sync_serial_xfer_bench.sv
`timescale 1ns/1ps
module sync_serial_xfer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sclk_in = 1'b1;
    logic       sclk_out, sclk_oe, sdo, xfer_irq;
    logic       ext_sdi = 1'b0;
    logic       m_sdi = 1'b0;
    logic       m_active = 1'b0;
    logic       sdi;

    int         checks = 0;
    int         errors = 0;

    // Reference model state for internal-clock transfers.
    int          m_k = 0;
    int          m_half = 1;
    int          m_len = 8;
    logic [15:0] m_tx = '0;
    logic [15:0] m_rx = '0;

    always #5 clk = ~clk;

    assign sdi = m_active ? m_sdi : ext_sdi;

    sync_serial_xfer u_sync_serial_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sclk_in   (sclk_in),
        .sclk_out  (sclk_out),
        .sclk_oe   (sclk_oe),
        .sdi       (sdi),
        .sdo       (sdo),
        .xfer_irq  (xfer_irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Cycle counter of the reference model.
    always @(posedge clk) if (m_active) m_k <= m_k + 1;

    // Per-clock comparison against the behavioural model (R3, R4, R6).
    always @(negedge clk) begin
        int t;
        int idx;
        if (m_active) begin
            t = m_k / m_half;
            if (t > 2 * m_len) t = 2 * m_len;
            idx = (t + 1) / 2;
            if (idx > 0) idx = idx - 1;
            m_sdi = m_rx[idx];
            check(sclk_out == ((t % 2) == 0), "R3 sclk_out", sclk_out, ((t % 2) == 0));
            check(sdo == m_tx[idx], "R4 sdo bit", sdo, m_tx[idx]);
            check(xfer_irq == (t == 2 * m_len), "R6 irq timing", xfer_irq, (t == 2 * m_len));
        end
    end

    // One internal-clock transfer under the model, then register checks.
    task automatic run_int(input bit wide, input int sel, input logic [15:0] tx, input logic [15:0] rx);
        logic [7:0] d;
        int len;
        len = wide ? 16 : 8;
        wr(2'd0, {1'b0, 1'b1, wide, 1'b0, 4'(sel)});
        wr(2'd1, tx[7:0]);
        wr(2'd2, tx[15:8]);
        m_half = 1 << sel;
        m_len  = len;
        m_tx   = tx;
        m_rx   = rx;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h09;
        @(negedge clk);
        reg_wr = 1'b0;
        m_k = 0;
        m_active = 1'b1;
        rd(2'd3, d);
        check(d[0] == 1'b1, "R2 start bit while running", d, 1);
        repeat (2 * len * m_half + 1) @(negedge clk);
        m_active = 1'b0;
        rd(2'd1, d);
        check(d == rx[7:0], "R5 lower byte", d, rx[7:0]);
        rd(2'd2, d);
        check(d == (wide ? rx[15:8] : tx[15:8]), "R5 upper byte", d, (wide ? rx[15:8] : tx[15:8]));
        rd(2'd3, d);
        check(d == 8'h0C, "R2 R6 status after completion", d, 8'h0C);
        check(sdo == tx[len-1], "R7 last bit held", sdo, tx[len-1]);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] etx, erx;
        bit         clk_ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, d); check(d == 8'h00, "R1 ctrl reset", d, 0);
        rd(2'd1, d); check(d == 8'h00, "R1 lower reset", d, 0);
        rd(2'd2, d); check(d == 8'h00, "R1 upper reset", d, 0);
        rd(2'd3, d); check(d == 8'h08, "R1 status reset", d, 8'h08);
        check(sclk_out && sclk_oe && sdo && !xfer_irq, "R1 outputs reset",
              {sclk_out, sclk_oe, sdo, xfer_irq}, 4'b1110);

        // R2-R7: internal transfers, several lengths and rates
        run_int(1'b0, 0, 16'h77A5, 16'h003C);
        // R6: writing 1 to the completion flag keeps it, writing 0 clears it
        wr(2'd3, 8'h0C);
        check(xfer_irq == 1'b1, "R6 write one no effect", xfer_irq, 1);
        wr(2'd3, 8'h08);
        check(xfer_irq == 1'b0, "R6 write zero clears", xfer_irq, 0);
        run_int(1'b1, 2, 16'hC3A1, 16'h5E69);
        run_int(1'b0, 1, 16'h1281, 16'h00D2);

        // R10: idle output level
        wr(2'd3, 8'h00);
        check(sdo == 1'b0, "R10 idle level low", sdo, 0);
        rd(2'd3, d); check(d[3] == 1'b0, "R10 level readback", d[3], 0);
        wr(2'd3, 8'h08);
        check(sdo == 1'b1, "R10 idle level high", sdo, 1);

        // R12: writes during a transfer are ignored
        ext_sdi = 1'b0;
        wr(2'd0, 8'h43);
        wr(2'd1, 8'h5A);
        wr(2'd3, 8'h09);
        repeat (10) @(negedge clk);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h09);
        repeat (112) @(negedge clk);
        check(xfer_irq == 1'b0, "R12 no early completion", xfer_irq, 0);
        repeat (4) @(negedge clk);
        check(xfer_irq == 1'b1, "R12 restart ignored, done on time", xfer_irq, 1);
        rd(2'd1, d); check(d == 8'h00, "R12 data write ignored", d, 0);

        // R11: abort by control write with hold bit clear
        wr(2'd0, 8'h63);
        wr(2'd3, 8'h09);
        repeat (20) @(negedge clk);
        wr(2'd0, 8'h23);
        rd(2'd3, d); check(d[0] == 1'b0, "R11 start bit cleared", d[0], 0);
        clk_ok = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!sclk_out || xfer_irq) clk_ok = 1'b0;
        end
        check(clk_ok, "R11 clock idle, no completion", clk_ok, 1);

        // R8, R9: external clock transfer and overrun
        etx = 8'h96; erx = 8'hB4;
        wr(2'd0, 8'h50);
        check(sclk_oe == 1'b0, "R8 clock not driven", sclk_oe, 0);
        wr(2'd1, etx);
        wr(2'd3, 8'h09);
        for (int j = 0; j < 8; j++) begin
            ext_sdi = erx[j];
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
            check(sdo == etx[j], "R8 external bit out", sdo, etx[j]);
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        check(xfer_irq == 1'b1, "R8 external completion", xfer_irq, 1);
        rd(2'd1, d); check(d == erx, "R8 external receive", d, erx);
        rd(2'd3, d); check(d == 8'h0C, "R9 no overrun yet", d, 8'h0C);
        check(sdo == etx[7], "R7 external last bit", sdo, etx[7]);
        sclk_in = 1'b0; ext_sdi = 1'b0;
        repeat (6) @(negedge clk);
        sclk_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd3, d); check(d == 8'h0E, "R9 overrun set", d, 8'h0E);
        rd(2'd1, d); check(d == erx, "R9 no shift on overrun", d, erx);
        wr(2'd3, 8'h08);
        rd(2'd3, d); check(d == 8'h08, "R9 overrun cleared", d, 8'h08);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule